// File: doc/BRIEF.md
# Region Access Permission Checker

This block sits on the request path of a single bus master and rules on each access as it arrives. Four address windows can be set up. Each window has its own enable, an inclusive lower and upper bound, and separate read, write and fetch rights for each of three privilege modes. Software configures the windows through a small register port. Once a window's lock bit is set, that window's bounds and rights are frozen until reset.

An access carries an address, a kind (read, write or fetch), a mode and a master ID. The block answers one cycle later with allow or deny. A denial has one of two causes. The first is a space fault: no enabled window covers the address. The second is a rights fault: at least one window covers the address, but none of them grants the needed right. The first denial is recorded in a status word and two info words, and it stays there until software clears it. An interrupt output is raised while a fault is recorded and interrupts are enabled.

Register map (byte offsets on `cfg_addr`):
- 0x00 control: bit 0 enables checking, bit 1 enables the interrupt.
- 0x04 window enables: one bit per window.
- 0x08 status, read only.
- 0x0C clear: writing a 1 in bit 0 clears the status.
- 0x10 info word 0.
- 0x14 info word 1.
- Window n: lower bound at 0x40+16n, upper bound at 0x44+16n, rights word at 0x48+16n.

Top module: `region_guard`

## Requirements
- R1: After reset the control word reads 0x1 (checking on, interrupt off) and the window enables read 0x1. Every lower bound reads 0 and every upper bound reads 0xFFFFFFFF. Every rights word reads 0. The status reads 0 and `irq` is low.
- R2: An access matches a window when that window is enabled and lower <= address <= upper. Both bounds are inclusive: the address one below the lower bound misses, and the address one above the upper bound misses.
- R3: In a rights word, mode m (0..2) has fetch at bit 4m, write at bit 4m+1 and read at bit 4m+2. An access is allowed if any window it matches has the bit for its kind and mode set, including when windows overlap. Kind code 0 is read, 1 is write, 2 is fetch, and 3 is treated as a read.
- R4: An access that matches no enabled window is denied, and status bit 1 (space fault) is recorded.
- R5: An access that matches at least one window, where no matched window grants the right, is denied. Status bit 0 (rights fault) is recorded, and info word 0 bits [3:0] hold the bitmap of the matched windows.
- R6: On a recorded fault, info word 0 holds the mode in bits [17:16] and the master ID in bits [22:18]. Info word 1 holds the full faulting address.
- R7: Only the first denial is recorded. Later denials leave the status and info words unchanged until a 1 is written to bit 0 of the clear register, which zeroes the status. If a clear and a new denial arrive in the same cycle, the clear wins and the denial is not recorded.
- R8: `irq` is high exactly when the status is nonzero and the interrupt enable is set.
- R9: While bit 11 of a window's rights word is set, writes to that window's lower bound, upper bound and rights word are ignored. Other windows stay writable.
- R10: An access from mode 3 is always allowed. While the checking enable is 0, every access is allowed and nothing is recorded.
- R11: `resp_valid` is high in the cycle after each cycle with `acc_valid` high, and only then. `resp_allow` carries the ruling in that cycle and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset, for both write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| acc_mode | input | 2 | Privilege mode |
| acc_id | input | ID_W | Master ID |
| resp_valid | output | 1 | Ruling is valid |
| resp_allow | output | 1 | 1 = allowed, 0 = denied |
| irq | output | 1 | Fault interrupt |

## Verification
A wrong window comparison or a wrong rights-bit index shows up as a wrong `resp_allow` one cycle after the access. The bench therefore probes each bound at its inclusive edge and tries each kind in turn. Fault-capture state that is wrong only becomes visible on a register read. For that reason, after every denial the bench reads back the status and info words, and it repeats the read after a second denial to confirm that the first record was kept. A lock that fails to hold can only be seen by reading the frozen window back after a write, and by repeating an access that the window should still allow.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    localparam int CFG_AW = 8;

    localparam logic [CFG_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [CFG_AW-1:0] OFS_WEN   = 8'h04;
    localparam logic [CFG_AW-1:0] OFS_STAT  = 8'h08;
    localparam logic [CFG_AW-1:0] OFS_CLR   = 8'h0C;
    localparam logic [CFG_AW-1:0] OFS_INFO0 = 8'h10;
    localparam logic [CFG_AW-1:0] OFS_INFO1 = 8'h14;

    localparam int WIN_BASE   = 64;
    localparam int WIN_STRIDE = 16;
    localparam int SUB_LO     = 0;
    localparam int SUB_HI     = 4;
    localparam int SUB_RIGHTS = 8;

    localparam int RIGHTS_W      = 12;
    localparam int LOCK_BIT      = 11;
    localparam int INFO_MODE_LSB = 16;
    localparam int INFO_ID_LSB   = 18;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    // bit 1: space fault, bit 0: rights fault
    typedef struct packed {
        logic space;
        logic rights;
    } fault_stat_t;

    function automatic logic [CFG_AW-1:0] win_ofs(input int idx, input int sub);
        return CFG_AW'(WIN_BASE + idx * WIN_STRIDE + sub);
    endfunction

    // Position of the right needed by (mode, kind); mode 3 never consults it.
    function automatic logic [3:0] right_index(input logic [1:0] mode, input acc_kind_e kind);
        logic [3:0] base;
        logic [3:0] off;
        base = {mode, 2'b00};
        case (kind)
            KIND_FETCH: off = 4'd0;
            KIND_WRITE: off = 4'd1;
            default:    off = 4'd2;
        endcase
        if (mode == 2'd3) return 4'd0;
        return base + off;
    endfunction

endpackage

// File: rtl/rg_regfile.sv
module rg_regfile
    import region_guard_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int ADDR_W = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [31:0]                       cfg_wdata,
    input  logic [1:0]                        stat_in,
    input  logic [31:0]                       info0_in,
    input  logic [31:0]                       info1_in,
    output logic [31:0]                       cfg_rdata,
    output logic                              func_en,
    output logic                              irq_en,
    output logic [NREG-1:0]                   win_en,
    output logic [NREG-1:0][ADDR_W-1:0]       w_lo,
    output logic [NREG-1:0][ADDR_W-1:0]       w_hi,
    output logic [NREG-1:0][RIGHTS_W-1:0]     w_rights,
    output logic [NREG-1:0]                   locked,
    output logic                              clr_pulse
);

    always_comb begin
        for (int i = 0; i < NREG; i++) locked[i] = w_rights[i][LOCK_BIT];
    end

    assign clr_pulse = cfg_we && (cfg_addr == OFS_CLR) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            func_en <= 1'b1;
            irq_en  <= 1'b0;
            win_en  <= NREG'(1);
        end else if (cfg_we) begin
            if (cfg_addr == OFS_CTRL) begin
                func_en <= cfg_wdata[0];
                irq_en  <= cfg_wdata[1];
            end
            if (cfg_addr == OFS_WEN) win_en <= cfg_wdata[NREG-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                w_lo[i]     <= '0;
                w_hi[i]     <= '1;
                w_rights[i] <= '0;
            end
        end else if (cfg_we) begin
            for (int i = 0; i < NREG; i++) begin
                if (!locked[i]) begin
                    if (cfg_addr == win_ofs(i, SUB_LO))     w_lo[i]     <= cfg_wdata[ADDR_W-1:0];
                    if (cfg_addr == win_ofs(i, SUB_HI))     w_hi[i]     <= cfg_wdata[ADDR_W-1:0];
                    if (cfg_addr == win_ofs(i, SUB_RIGHTS)) w_rights[i] <= cfg_wdata[RIGHTS_W-1:0];
                end
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == OFS_CTRL)  cfg_rdata = {30'b0, irq_en, func_en};
        if (cfg_addr == OFS_WEN)   cfg_rdata = 32'(win_en);
        if (cfg_addr == OFS_STAT)  cfg_rdata = {30'b0, stat_in};
        if (cfg_addr == OFS_INFO0) cfg_rdata = info0_in;
        if (cfg_addr == OFS_INFO1) cfg_rdata = info1_in;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_addr == win_ofs(i, SUB_LO))     cfg_rdata = 32'(w_lo[i]);
            if (cfg_addr == win_ofs(i, SUB_HI))     cfg_rdata = 32'(w_hi[i]);
            if (cfg_addr == win_ofs(i, SUB_RIGHTS)) cfg_rdata = 32'(w_rights[i]);
        end
    end

endmodule

// File: rtl/rg_window_match.sv
module rg_window_match
    import region_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                enable,
    input  logic [ADDR_W-1:0]   lo,
    input  logic [ADDR_W-1:0]   hi,
    input  logic [RIGHTS_W-1:0] rights,
    input  logic [ADDR_W-1:0]   addr,
    input  acc_kind_e           kind,
    input  logic [1:0]          mode,
    output logic                hit,
    output logic                grant
);

    logic [3:0] idx;

    always_comb begin
        idx   = right_index(mode, kind);
        hit   = enable && (addr >= lo) && (addr <= hi);
        grant = hit && (mode != 2'd3) && rights[idx];
    end

endmodule

// File: rtl/rg_fault_log.sv
module rg_fault_log
    import region_guard_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deny,
    input  logic [NREG-1:0]   hit_map,
    input  logic [1:0]        mode,
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clr,
    output fault_stat_t       status,
    output logic [31:0]       info0,
    output logic [31:0]       info1
);

    logic [NREG-1:0]   map_q;
    logic [1:0]        mode_q;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            map_q  <= '0;
            mode_q <= '0;
            id_q   <= '0;
            addr_q <= '0;
        end else if (clr) begin
            status <= '0;
        end else if (deny && (status == '0)) begin
            status.space  <= (hit_map == '0);
            status.rights <= (hit_map != '0);
            map_q  <= hit_map;
            mode_q <= mode;
            id_q   <= id;
            addr_q <= addr;
        end
    end

    always_comb begin
        info0 = '0;
        info0[NREG-1:0] = map_q;
        info0[INFO_MODE_LSB +: 2] = mode_q;
        info0[INFO_ID_LSB +: ID_W] = id_q;
        info1 = 32'(addr_q);
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int ADDR_W = 32,
    parameter int ID_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_mode,
    input  logic [ID_W-1:0]   acc_id,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic              irq
);

    logic                          func_en;
    logic                          irq_en;
    logic [NREG-1:0]               win_en;
    logic [NREG-1:0][ADDR_W-1:0]   w_lo;
    logic [NREG-1:0][ADDR_W-1:0]   w_hi;
    logic [NREG-1:0][RIGHTS_W-1:0] w_rights;
    logic [NREG-1:0]               locked;
    logic                          clr_pulse;
    fault_stat_t                   fault_status;
    logic [31:0]                   info0;
    logic [31:0]                   info1;
    logic [NREG-1:0]               hit;
    logic [NREG-1:0]               grant;
    logic                          bypass;
    logic                          allow_now;
    logic                          deny_now;

    rg_regfile #(.NREG(NREG), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .stat_in(fault_status), .info0_in(info0), .info1_in(info1),
        .cfg_rdata(cfg_rdata),
        .func_en(func_en), .irq_en(irq_en), .win_en(win_en),
        .w_lo(w_lo), .w_hi(w_hi), .w_rights(w_rights),
        .locked(locked), .clr_pulse(clr_pulse)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_win
        rg_window_match #(.ADDR_W(ADDR_W)) u_match (
            .enable(win_en[g]), .lo(w_lo[g]), .hi(w_hi[g]), .rights(w_rights[g]),
            .addr(acc_addr), .kind(acc_kind_e'(acc_kind)), .mode(acc_mode),
            .hit(hit[g]), .grant(grant[g])
        );
    end

    always_comb begin
        bypass    = !func_en || (acc_mode == 2'd3);
        allow_now = bypass || (grant != '0);
        deny_now  = acc_valid && !allow_now;
    end

    rg_fault_log #(.NREG(NREG), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_log (
        .clk(clk), .rst(rst), .deny(deny_now), .hit_map(hit),
        .mode(acc_mode), .id(acc_id), .addr(acc_addr), .clr(clr_pulse),
        .status(fault_status), .info0(info0), .info1(info1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= acc_valid;
            resp_allow <= acc_valid && allow_now;
        end
    end

    assign irq = irq_en && (fault_status != '0);

endmodule

// File: rtl/rg_checker.sv
module rg_checker
    import region_guard_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc_valid,
    input  logic [1:0]                    acc_mode,
    input  logic                          resp_valid,
    input  logic                          resp_allow,
    input  logic                          irq,
    input  logic [1:0]                    status,
    input  logic                          clr_pulse,
    input  logic [NREG-1:0]               locked,
    input  logic [NREG-1:0][ADDR_W-1:0]   w_lo,
    input  logic [NREG-1:0][ADDR_W-1:0]   w_hi,
    input  logic [NREG-1:0][RIGHTS_W-1:0] w_rights
);

    assert_resp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> resp_valid);

    assert_resp_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!resp_valid && !resp_allow));

    assert_mode3_pass_R10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode == 2'd3) |=> resp_allow);

    assert_first_held_R7: assert property (@(posedge clk) disable iff (rst)
        (status != 2'b00 && !clr_pulse) |=> $stable(status));

    assert_deny_logged_R7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_allow && !$past(clr_pulse)) |-> (status != 2'b00));

    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b00) |-> !irq);

    for (genvar g = 0; g < NREG; g++) begin : g_lock
        assert_lock_hold_R9: assert property (@(posedge clk) disable iff (rst)
            locked[g] |=> ($stable(w_lo[g]) && $stable(w_hi[g]) && $stable(w_rights[g])));
    end

endmodule

bind region_guard rg_checker #(.NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_mode(acc_mode),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .irq(irq),
    .status(fault_status), .clr_pulse(clr_pulse), .locked(locked),
    .w_lo(w_lo), .w_hi(w_hi), .w_rights(w_rights)
);

// File: tb/sim_region_guard.sv
module sim_region_guard;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_mode = '0;
    logic [4:0]  acc_id = '0;
    logic        resp_valid;
    logic        resp_allow;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    region_guard u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_mode(acc_mode),
        .acc_id(acc_id), .resp_valid(resp_valid), .resp_allow(resp_allow), .irq(irq)
    );

    // Monitor: pops one expected ruling per response.
    always @(negedge clk) begin : monitor
        bit    e;
        string t;
        if (!rst && resp_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_errors++;
                $display("FAIL R11 unexpected response actual=1 expected=0");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (resp_allow !== e) begin
                    n_errors++;
                    $display("FAIL %s allow actual=%0b expected=%0b", t, resp_allow, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        n_checks++;
        if (cfg_rdata !== exp) begin
            n_errors++;
            $display("FAIL %s reg 0x%02h actual=0x%08h expected=0x%08h", tag, a, cfg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        #1;
        n_checks++;
        if (irq !== exp) begin
            n_errors++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic [1:0] m,
                          input logic [4:0] id, input bit exp, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_mode = m; acc_id = id;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_reg(8'h00, 32'h1, "R1");
        chk_reg(8'h04, 32'h1, "R1");
        chk_reg(8'h40, 32'h0, "R1");
        chk_reg(8'h44, 32'hFFFF_FFFF, "R1");
        chk_reg(8'h48, 32'h0, "R1");
        chk_reg(8'h08, 32'h0, "R1");
        chk_irq(1'b0, "R1");

        // R5/R6: window 0 covers everything but grants nothing
        access(32'h0000_1234, RD, 2'd0, 5'd5, 1'b0, "R5");
        chk_reg(8'h08, 32'h1, "R5");
        chk_reg(8'h10, 32'h0014_0001, "R6");
        chk_reg(8'h14, 32'h0000_1234, "R6");

        // R7: second denial keeps the first record
        wr(8'h04, 32'h0);
        access(32'h0000_0010, RD, 2'd1, 5'd2, 1'b0, "R4");
        chk_reg(8'h08, 32'h1, "R7");
        chk_reg(8'h14, 32'h0000_1234, "R7");
        chk_irq(1'b0, "R8");
        wr(8'h00, 32'h3);
        chk_irq(1'b1, "R8");
        wr(8'h0C, 32'h1);
        chk_reg(8'h08, 32'h0, "R7");
        chk_irq(1'b0, "R8");

        // Window 1: [0x1000,0x1FFF], mode1 read, mode0 write
        wr(8'h50, 32'h0000_1000);
        wr(8'h54, 32'h0000_1FFF);
        wr(8'h58, 32'h0000_0042);
        wr(8'h04, 32'h2);
        access(32'h0000_1000, RD, 2'd1, 5'd1, 1'b1, "R2");
        access(32'h0000_1FFF, RD, 2'd1, 5'd1, 1'b1, "R2");
        access(32'h0000_0FFF, RD, 2'd1, 5'd7, 1'b0, "R2");
        chk_reg(8'h08, 32'h2, "R4");
        chk_reg(8'h10, 32'h001D_0000, "R6");
        chk_reg(8'h14, 32'h0000_0FFF, "R6");
        chk_irq(1'b1, "R8");
        wr(8'h0C, 32'h1);
        access(32'h0000_2000, RD, 2'd1, 5'd1, 1'b0, "R2");
        chk_reg(8'h08, 32'h2, "R4");
        wr(8'h0C, 32'h1);

        // R3 rights bit positions
        access(32'h0000_1800, WR, 2'd0, 5'd1, 1'b1, "R3");
        access(32'h0000_1800, WR, 2'd1, 5'd1, 1'b0, "R3");
        chk_reg(8'h08, 32'h1, "R3");
        wr(8'h0C, 32'h1);
        access(32'h0000_1800, EX, 2'd2, 5'd1, 1'b0, "R3");
        wr(8'h0C, 32'h1);
        access(32'h0000_1800, RD, 2'd0, 5'd1, 1'b0, "R3");
        wr(8'h0C, 32'h1);

        // Overlap: window 2 [0x1800,0x27FF] grants mode2 fetch
        wr(8'h60, 32'h0000_1800);
        wr(8'h64, 32'h0000_27FF);
        wr(8'h68, 32'h0000_0100);
        wr(8'h04, 32'h6);
        access(32'h0000_1900, EX, 2'd2, 5'd3, 1'b1, "R3");
        access(32'h0000_2700, EX, 2'd2, 5'd3, 1'b1, "R3");
        access(32'h0000_1900, RD, 2'd0, 5'd3, 1'b0, "R5");
        chk_reg(8'h08, 32'h1, "R5");
        chk_reg(8'h10, 32'h000C_0006, "R5");
        wr(8'h0C, 32'h1);

        // R10 bypasses
        access(32'h0000_5000, RD, 2'd3, 5'd4, 1'b1, "R10");
        chk_reg(8'h08, 32'h0, "R10");
        wr(8'h00, 32'h2);
        access(32'h0000_5000, RD, 2'd0, 5'd4, 1'b1, "R10");
        chk_reg(8'h08, 32'h0, "R10");
        wr(8'h00, 32'h3);

        // R9 lock
        wr(8'h58, 32'h0000_0842);
        wr(8'h50, 32'h0000_3000);
        wr(8'h58, 32'h0000_0000);
        chk_reg(8'h50, 32'h0000_1000, "R9");
        chk_reg(8'h58, 32'h0000_0842, "R9");
        access(32'h0000_1000, RD, 2'd1, 5'd1, 1'b1, "R9");
        wr(8'h60, 32'h0000_1C00);
        chk_reg(8'h60, 32'h0000_1C00, "R9");

        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_errors++;
            $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule